// File: doc/BRIEF.md
# Accumulator Rotate and Carry-Bit Unit

This execution unit sits in the datapath of a small 8-bit processor. It performs one-position rotates of the 8-bit accumulator, both plain and through the carry flag, and a left rotate through carry of a 16-bit register pair. It also treats the carry flag as a one-bit Boolean accumulator. It can copy one selected bit of an operand byte into the carry, write the carry back into that bit, or combine the carry with that bit by AND or OR. The surrounding core decodes the instruction and presents a 3-bit operation code, a direction bit and the source values, then pulses `issue_i` for one clock.

One clock after an issue, the unit presents the new values on registered outputs. It also raises a one-cycle write strobe for each destination the operation really updates. An output that is not written keeps its previous value. Zero and auxiliary-carry are not produced here, so they stay with the core unchanged.

Operation codes (`op_i`): 0 rotate right, 1 rotate left, 2 rotate right through carry, 3 rotate left through carry, 4 word rotate left through carry, 5 bit move, 6 bit AND, 7 bit OR.

Top module: `rbu_top`

## Requirements
- R1: While `rst` is high at a clock edge, every output register is cleared: all data outputs are 0, the carry output is 0 and every strobe is 0.
- R2: The results of an issue appear on the outputs exactly one clock after the edge that samples `issue_i`=1. A strobe is high for that one cycle only, and all strobes are low after an edge where `issue_i` was 0.
- R3: Op 0 (rotate right): bit m of the accumulator moves to bit m-1, and the old bit 0 goes to both bit 7 and the carry.
- R4: Op 1 (rotate left): bit m moves to bit m+1, and the old bit 7 goes to both bit 0 and the carry.
- R5: Op 2 (rotate right through carry): the carry takes the old bit 0, bit 7 takes the old carry, and the other bits move down by one.
- R6: Op 3 (rotate left through carry): the carry takes the old bit 7, bit 0 takes the old carry, and the other bits move up by one.
- R7: Op 4 (word rotate): the carry takes the old bit 15 of `word_i`, bit 0 takes the old carry, and each bit m moves to m+1.
- R8: Op 5 with `to_bit_i`=0: the carry takes bit `bsel_i` of `opnd_i`, where index 0 is the least significant bit.
- R9: Op 5 with `to_bit_i`=1: `opnd_o` equals `opnd_i` with bit `bsel_i` replaced by the carry, the other seven bits are unchanged, and the carry output is not written.
- R10: Op 6 sets the carry to carry AND bit `bsel_i` of `opnd_i`. Op 7 sets the carry to carry OR that bit. Neither op writes the operand.
- R11: The strobes cover these destinations. `acc_we_o` is high for ops 0 to 3, `word_we_o` for op 4, and `opnd_we_o` for op 5 with `to_bit_i`=1. `cy_we_o` is high for every other issued op. Any data output whose strobe is low keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Start one operation this cycle |
| op_i | input | 3 | Operation code |
| to_bit_i | input | 1 | Bit move direction: 0 into carry, 1 into operand bit |
| acc_i | input | 8 | Accumulator value |
| word_i | input | 16 | Register pair value |
| opnd_i | input | 8 | Operand byte for bit operations |
| bsel_i | input | 3 | Selected bit index |
| cy_i | input | 1 | Current carry flag |
| acc_o | output | 8 | New accumulator |
| word_o | output | 16 | New register pair |
| opnd_o | output | 8 | New operand byte |
| cy_o | output | 1 | New carry flag |
| acc_we_o | output | 1 | Accumulator write strobe |
| word_we_o | output | 1 | Register pair write strobe |
| opnd_we_o | output | 1 | Operand write strobe |
| cy_we_o | output | 1 | Carry write strobe |

## Verification
Directed single-bit patterns come first. These are 0x01 and 0x80 on the accumulator and 0x8000 on the word, each with the carry both set and clear. They separate plain rotates from rotates through carry and catch a wrong direction or a lost end bit. Bit operations are tried at indices 0 and 7 against operand bytes of alternating and solid patterns. This shows whether the index counts from the correct end and whether a write-back disturbs neighbouring bits. Random operands, indices, carries and operations are then mixed with idle cycles. The mix shows that outputs which are not written hold their values and that each strobe lasts one cycle.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
  typedef enum logic [2:0] {
    OP_RR   = 3'd0,
    OP_RL   = 3'd1,
    OP_RRC  = 3'd2,
    OP_RLC  = 3'd3,
    OP_WRLC = 3'd4,
    OP_BMOV = 3'd5,
    OP_BAND = 3'd6,
    OP_BOR  = 3'd7
  } rbu_op_e;

  typedef enum logic [1:0] {
    BOP_TO_CY  = 2'd0,
    BOP_TO_BIT = 2'd1,
    BOP_AND    = 2'd2,
    BOP_OR     = 2'd3
  } rbu_bop_e;
endpackage

// File: rtl/rbu_rotator.sv
module rbu_rotator #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  logic         cin,
  input  logic         left,
  input  logic         thru,
  output logic [W-1:0] dout,
  output logic         cout
);
  logic fill;

  always_comb begin
    if (left) begin
      fill = thru ? cin : din[W-1];
      dout = {din[W-2:0], fill};
      cout = din[W-1];
    end else begin
      fill = thru ? cin : din[0];
      dout = {fill, din[W-1:1]};
      cout = din[0];
    end
  end
endmodule

// File: rtl/rbu_bitop.sv
module rbu_bitop
  import rbu_pkg::*;
#(
  parameter int W     = 8,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     din,
  input  logic [IDX_W-1:0] idx,
  input  logic             cin,
  input  rbu_bop_e         bop,
  output logic [W-1:0]     dout,
  output logic             cout
);
  logic sel_bit;

  assign sel_bit = din[idx];

  // per-bit write-back mux: only the addressed position may take the carry
  for (genvar i = 0; i < W; i++) begin : g_wb
    assign dout[i] = (bop == BOP_TO_BIT && idx == IDX_W'(i)) ? cin : din[i];
  end

  always_comb begin
    unique case (bop)
      BOP_TO_CY:  cout = sel_bit;
      BOP_AND:    cout = cin & sel_bit;
      BOP_OR:     cout = cin | sel_bit;
      default:    cout = cin;
    endcase
  end
endmodule

// File: rtl/rbu_top.sv
module rbu_top
  import rbu_pkg::*;
#(
  parameter int ACC_W  = 8,
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(ACC_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_i,
  input  logic [2:0]        op_i,
  input  logic              to_bit_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [ACC_W-1:0]  opnd_i,
  input  logic [IDX_W-1:0]  bsel_i,
  input  logic              cy_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [WORD_W-1:0] word_o,
  output logic [ACC_W-1:0]  opnd_o,
  output logic              cy_o,
  output logic              acc_we_o,
  output logic              word_we_o,
  output logic              opnd_we_o,
  output logic              cy_we_o
);
  rbu_op_e           op;
  logic              acc_left, acc_thru;
  logic [ACC_W-1:0]  acc_rot;
  logic              acc_cy;
  logic [WORD_W-1:0] word_rot;
  logic              word_cy;
  rbu_bop_e          bop;
  logic [ACC_W-1:0]  opnd_new;
  logic              bit_cy;
  logic              wr_acc, wr_word, wr_opnd, wr_cy;
  logic              cy_next;

  assign op       = rbu_op_e'(op_i);
  assign acc_left = (op == OP_RL)  || (op == OP_RLC);
  assign acc_thru = (op == OP_RRC) || (op == OP_RLC);

  rbu_rotator #(.W(ACC_W)) u_acc_rot (
    .din (acc_i), .cin (cy_i), .left (acc_left), .thru (acc_thru),
    .dout(acc_rot), .cout(acc_cy)
  );

  rbu_rotator #(.W(WORD_W)) u_word_rot (
    .din (word_i), .cin (cy_i), .left (1'b1), .thru (1'b1),
    .dout(word_rot), .cout(word_cy)
  );

  always_comb begin
    unique case (op)
      OP_BMOV: bop = to_bit_i ? BOP_TO_BIT : BOP_TO_CY;
      OP_BAND: bop = BOP_AND;
      OP_BOR:  bop = BOP_OR;
      default: bop = BOP_TO_CY;
    endcase
  end

  rbu_bitop #(.W(ACC_W), .IDX_W(IDX_W)) u_bitop (
    .din (opnd_i), .idx (bsel_i), .cin (cy_i), .bop (bop),
    .dout(opnd_new), .cout(bit_cy)
  );

  always_comb begin
    wr_acc  = issue_i && (op == OP_RR || op == OP_RL || op == OP_RRC || op == OP_RLC);
    wr_word = issue_i && (op == OP_WRLC);
    wr_opnd = issue_i && (op == OP_BMOV) && to_bit_i;
    wr_cy   = issue_i && !wr_opnd;
    if (wr_acc)       cy_next = acc_cy;
    else if (wr_word) cy_next = word_cy;
    else              cy_next = bit_cy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o     <= '0;
      word_o    <= '0;
      opnd_o    <= '0;
      cy_o      <= 1'b0;
      acc_we_o  <= 1'b0;
      word_we_o <= 1'b0;
      opnd_we_o <= 1'b0;
      cy_we_o   <= 1'b0;
    end else begin
      acc_we_o  <= wr_acc;
      word_we_o <= wr_word;
      opnd_we_o <= wr_opnd;
      cy_we_o   <= wr_cy;
      if (wr_acc)  acc_o  <= acc_rot;
      if (wr_word) word_o <= word_rot;
      if (wr_opnd) opnd_o <= opnd_new;
      if (wr_cy)   cy_o   <= cy_next;
    end
  end
endmodule

// File: rtl/rbu_checker.sv
module rbu_checker #(
  parameter int ACC_W  = 8,
  parameter int WORD_W = 16,
  localparam int IDX_W = $clog2(ACC_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              issue_i,
  input logic [2:0]        op_i,
  input logic              to_bit_i,
  input logic [ACC_W-1:0]  acc_i,
  input logic [WORD_W-1:0] word_i,
  input logic [ACC_W-1:0]  opnd_i,
  input logic [IDX_W-1:0]  bsel_i,
  input logic              cy_i,
  input logic [ACC_W-1:0]  acc_o,
  input logic [WORD_W-1:0] word_o,
  input logic [ACC_W-1:0]  opnd_o,
  input logic              cy_o,
  input logic              acc_we_o,
  input logic              word_we_o,
  input logic              opnd_we_o,
  input logic              cy_we_o
);
  assert_idle_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(issue_i) |-> !(acc_we_o || word_we_o || opnd_we_o || cy_we_o));

  assert_ror_R3: assert property (@(posedge clk) disable iff (rst)
    (issue_i && op_i == 3'd0) |=>
      (acc_o == {$past(acc_i[0]), $past(acc_i[ACC_W-1:1])}) && (cy_o == $past(acc_i[0])));

  assert_rolc_R6: assert property (@(posedge clk) disable iff (rst)
    (issue_i && op_i == 3'd3) |=>
      (acc_o == {$past(acc_i[ACC_W-2:0]), $past(cy_i)}) && (cy_o == $past(acc_i[ACC_W-1])));

  assert_word_rot_R7: assert property (@(posedge clk) disable iff (rst)
    (issue_i && op_i == 3'd4) |=>
      (word_o == {$past(word_i[WORD_W-2:0]), $past(cy_i)}) && (cy_o == $past(word_i[WORD_W-1])));

  assert_bit_to_cy_R8: assert property (@(posedge clk) disable iff (rst)
    (issue_i && op_i == 3'd5 && !to_bit_i) |=> cy_we_o && (cy_o == $past(opnd_i[bsel_i])));

  assert_bit_write_R9: assert property (@(posedge clk) disable iff (rst)
    (issue_i && op_i == 3'd5 && to_bit_i) |=>
      opnd_we_o && !cy_we_o && (opnd_o[$past(bsel_i)] == $past(cy_i)) &&
      ((opnd_o & ~(ACC_W'(1) << $past(bsel_i))) == ($past(opnd_i) & ~(ACC_W'(1) << $past(bsel_i)))));

  assert_and_or_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    (issue_i && (op_i == 3'd6 || op_i == 3'd7)) |=> !opnd_we_o && cy_we_o);

  assert_acc_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!acc_we_o && !$past(rst)) |-> $stable(acc_o));

  assert_word_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!word_we_o && !$past(rst)) |-> $stable(word_o));

  assert_opnd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!opnd_we_o && !$past(rst)) |-> $stable(opnd_o));
endmodule

bind rbu_top rbu_checker #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .issue_i(issue_i), .op_i(op_i), .to_bit_i(to_bit_i),
  .acc_i(acc_i), .word_i(word_i), .opnd_i(opnd_i), .bsel_i(bsel_i), .cy_i(cy_i),
  .acc_o(acc_o), .word_o(word_o), .opnd_o(opnd_o), .cy_o(cy_o),
  .acc_we_o(acc_we_o), .word_we_o(word_we_o), .opnd_we_o(opnd_we_o), .cy_we_o(cy_we_o)
);

// File: tb/tb_rbu_top.sv
`timescale 1ns/1ps
module tb_rbu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic        to_bit_i = 1'b0;
  logic [7:0]  acc_i = '0;
  logic [15:0] word_i = '0;
  logic [7:0]  opnd_i = '0;
  logic [2:0]  bsel_i = '0;
  logic        cy_i = 1'b0;
  logic [7:0]  acc_o;
  logic [15:0] word_o;
  logic [7:0]  opnd_o;
  logic        cy_o, acc_we_o, word_we_o, opnd_we_o, cy_we_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  rbu_top dut (
    .clk(clk), .rst(rst), .issue_i(issue_i), .op_i(op_i), .to_bit_i(to_bit_i),
    .acc_i(acc_i), .word_i(word_i), .opnd_i(opnd_i), .bsel_i(bsel_i), .cy_i(cy_i),
    .acc_o(acc_o), .word_o(word_o), .opnd_o(opnd_o), .cy_o(cy_o),
    .acc_we_o(acc_we_o), .word_we_o(word_we_o), .opnd_we_o(opnd_we_o), .cy_we_o(cy_we_o)
  );

  typedef struct {
    logic [7:0]  acc;
    logic [15:0] word;
    logic [7:0]  opnd;
    logic        cy;
    logic [3:0]  we;   // {acc, word, opnd, cy}
    int          req;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  m_acc = '0;
  logic [15:0] m_word = '0;
  logic [7:0]  m_opnd = '0;
  logic        m_cy = 1'b0;
  logic        drove = 1'b0;
  logic        due = 1'b0;

  always @(posedge clk) due <= drove;

  // monitor: one expected item per driven cycle, compared one clock later
  always @(negedge clk) begin
    if (due) begin
      if (sb.size() == 0) begin
        total++; bad++;
        $display("FAIL R2: output cycle with no expected item");
      end else begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (acc_o !== e.acc || word_o !== e.word || opnd_o !== e.opnd || cy_o !== e.cy) begin
          bad++;
          $display("FAIL R%0d: acc=%h word=%h opnd=%h cy=%b expected acc=%h word=%h opnd=%h cy=%b",
                   e.req, acc_o, word_o, opnd_o, cy_o, e.acc, e.word, e.opnd, e.cy);
        end
        total++;   // R11 strobe set
        if ({acc_we_o, word_we_o, opnd_we_o, cy_we_o} !== e.we) begin
          bad++;
          $display("FAIL R11 (req R%0d): strobes=%b expected=%b", e.req,
                   {acc_we_o, word_we_o, opnd_we_o, cy_we_o}, e.we);
        end
      end
    end
  end

  task automatic do_op(input logic [2:0] op, input logic tb, input logic [7:0] a,
                       input logic [15:0] w, input logic [7:0] o, input logic [2:0] idx,
                       input logic c);
    exp_t e;
    @(negedge clk);
    issue_i = 1'b1; op_i = op; to_bit_i = tb; acc_i = a; word_i = w;
    opnd_i = o; bsel_i = idx; cy_i = c;
    e.we = 4'b0000;
    case (op)
      3'd0: begin m_acc = {a[0], a[7:1]}; m_cy = a[0]; e.we = 4'b1001; e.req = 3; end  // R3
      3'd1: begin m_acc = {a[6:0], a[7]}; m_cy = a[7]; e.we = 4'b1001; e.req = 4; end  // R4
      3'd2: begin m_acc = {c, a[7:1]};    m_cy = a[0]; e.we = 4'b1001; e.req = 5; end  // R5
      3'd3: begin m_acc = {a[6:0], c};    m_cy = a[7]; e.we = 4'b1001; e.req = 6; end  // R6
      3'd4: begin m_word = {w[14:0], c};  m_cy = w[15]; e.we = 4'b0101; e.req = 7; end // R7
      3'd5: begin
        if (tb) begin                                                                  // R9
          m_opnd = o; m_opnd[idx] = c; e.we = 4'b0010; e.req = 9;
        end else begin                                                                 // R8
          m_cy = o[idx]; e.we = 4'b0001; e.req = 8;
        end
      end
      3'd6: begin m_cy = c & o[idx]; e.we = 4'b0001; e.req = 10; end                   // R10
      default: begin m_cy = c | o[idx]; e.we = 4'b0001; e.req = 10; end                // R10
    endcase
    e.acc = m_acc; e.word = m_word; e.opnd = m_opnd; e.cy = m_cy;
    sb.push_back(e);
    drove = 1'b1;
  endtask

  task automatic idle();
    exp_t e;
    @(negedge clk);
    issue_i = 1'b0;
    acc_i = 8'($urandom); word_i = 16'($urandom); opnd_i = 8'($urandom); cy_i = 1'($urandom);
    op_i = 3'($urandom);
    e.acc = m_acc; e.word = m_word; e.opnd = m_opnd; e.cy = m_cy; e.we = 4'b0000;
    e.req = 2;   // R2: no strobe without issue, values held
    sb.push_back(e);
    drove = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog: run did not complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;   // R1 reset state
    if ({acc_o, word_o, opnd_o, cy_o, acc_we_o, word_we_o, opnd_we_o, cy_we_o} !== '0) begin
      bad++;
      $display("FAIL R1: outputs %h %h %h %b strobes %b expected all zero",
               acc_o, word_o, opnd_o, cy_o, {acc_we_o, word_we_o, opnd_we_o, cy_we_o});
    end
    rst = 1'b0;

    // directed corner patterns
    do_op(3'd0, 0, 8'h01, 16'h0, 8'h00, 3'd0, 1'b0);   // R3 bit0 wraps to bit7
    do_op(3'd1, 0, 8'h80, 16'h0, 8'h00, 3'd0, 1'b0);   // R4 bit7 wraps to bit0
    do_op(3'd2, 0, 8'h01, 16'h0, 8'h00, 3'd0, 1'b0);   // R5 carry 0 into bit7
    do_op(3'd2, 0, 8'h00, 16'h0, 8'h00, 3'd0, 1'b1);   // R5 carry 1 into bit7
    do_op(3'd3, 0, 8'h80, 16'h0, 8'h00, 3'd0, 1'b0);   // R6
    do_op(3'd3, 0, 8'h00, 16'h0, 8'h00, 3'd0, 1'b1);   // R6
    idle();
    do_op(3'd4, 0, 8'h00, 16'h8000, 8'h00, 3'd0, 1'b0); // R7
    do_op(3'd4, 0, 8'h00, 16'h1234, 8'h00, 3'd0, 1'b1); // R7
    do_op(3'd5, 0, 8'h00, 16'h0, 8'h01, 3'd0, 1'b0);   // R8 index 0
    do_op(3'd5, 0, 8'h7F, 16'h0, 8'h7F, 3'd7, 1'b1);   // R8 index 7
    do_op(3'd5, 1, 8'h00, 16'h0, 8'h55, 3'd7, 1'b1);   // R9 write bit7
    do_op(3'd5, 1, 8'h00, 16'h0, 8'hFF, 3'd0, 1'b0);   // R9 clear bit0
    do_op(3'd6, 0, 8'h00, 16'h0, 8'hFE, 3'd0, 1'b1);   // R10 AND -> 0
    do_op(3'd6, 0, 8'h00, 16'h0, 8'h80, 3'd7, 1'b1);   // R10 AND -> 1
    do_op(3'd7, 0, 8'h00, 16'h0, 8'h01, 3'd0, 1'b0);   // R10 OR -> 1
    do_op(3'd7, 0, 8'h00, 16'h0, 8'h7F, 3'd7, 1'b0);   // R10 OR -> 0
    idle();
    idle();

    for (int i = 0; i < 800; i++) begin
      if ($urandom_range(3) == 0) idle();
      else do_op(3'($urandom), 1'($urandom), 8'($urandom), 16'($urandom),
                 8'($urandom), 3'($urandom), 1'($urandom));
    end

    @(negedge clk);
    issue_i = 1'b0;
    drove = 1'b0;
    repeat (3) @(negedge clk);
    total++;
    if (sb.size() != 0) begin
      bad++;
      $display("FAIL R2: %0d expected items never produced, expected 0", sb.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule